// File: doc/BRIEF.md
# Receiver Bring-Up Reset Sequencer

This block orders the resets of a source-synchronous receiver channel as it starts up. The channel has a clock PLL, a phase-alignment unit, a clock-crossing FIFO and a bitslip stage. A start or restart request asserts the PLL reset and the phase-alignment reset together. The sequencer then holds the PLL reset for a minimum time and waits until PLL lock has stayed high for long enough. After that it releases each later stage in turn. At the end it hands control to external word-alignment logic, and it raises an interface-ready flag once that logic reports success.

Two modes are supported. In phase-aligned mode the sequencer waits for the phase-alignment unit to lock. It then pulses the FIFO reset, waits a short settling gap, and pulses the bitslip reset. In non-aligned mode the phase-alignment unit stays in reset and the FIFO reset never fires. The bitslip pulse follows as soon as the PLL lock is qualified. The mode is captured when a start request arrives. If PLL lock is lost once the phase-alignment stage has been reached, the whole sequence starts again from the PLL reset.

The sequencer runs from a free-running parallel clock and uses a synchronous active-high reset. The PLL, the phase-alignment logic and the FIFO are outside this block.

Top module: `rx_bringup_seq`

## Requirements
- R1: After reset and until the first start request, `pll_rst_o` and `pa_rst_o` are high, and `fifo_rst_o`, `bslip_rst_o`, `align_go_o` and `link_ready_o` are low.
- R2: A start request seen at a clock edge in any state makes `pll_rst_o` and `pa_rst_o` high after that edge and clears `fifo_rst_o`, `bslip_rst_o`, `align_go_o` and `link_ready_o`.
- R3: When the sequence (re)starts, `pll_rst_o` stays high for exactly ceil(PLL_RST_MIN_NS / CLK_PERIOD_NS) cycles, with a minimum of one, and then falls.
- R4: After the PLL reset is released, the sequence moves on only once `pll_locked_i` has been high at LOCK_STABLE_CYC consecutive clock edges. It moves on at the next edge. Any low cycle restarts the count.
- R5: In phase-aligned mode, `pa_rst_o` falls when the PLL lock is qualified. The sequencer then waits for `pa_locked_i`. `fifo_rst_o` rises at the edge after `pa_locked_i` is seen and stays high for FIFO_RST_CYC cycles.
- R6: After the FIFO reset falls, `fifo_rst_o` and `bslip_rst_o` both stay low for max(FIFO_GAP_CYC, 2) cycles. Then `bslip_rst_o` is high for BSLIP_RST_CYC cycles.
- R7: In non-aligned mode, `fifo_rst_o` never rises and `pa_rst_o` stays high. `bslip_rst_o` rises at the edge after the PLL lock is qualified.
- R8: When the bitslip pulse ends, `align_go_o` goes high and stays high until `align_done_i` is seen. `align_done_i` has no effect in any other state.
- R9: `link_ready_o` rises at the edge after `align_done_i` is seen while `align_go_o` is high, at which point `align_go_o` falls. It stays high until a restart.
- R10: If `pll_locked_i` is low at an edge in any state from the phase-alignment wait onward, the sequence returns to the PLL reset hold. `pll_rst_o` and `pa_rst_o` rise, and `link_ready_o` falls.
- R11: The mode select (`mode_aligned_i` = 1 for phase-aligned) is sampled only when a start request is seen. Changing it later does not alter the outputs or the path the sequence takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running parallel clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req_i | input | 1 | Start or restart request |
| mode_aligned_i | input | 1 | 1 selects phase-aligned mode, 0 selects non-aligned mode |
| pll_locked_i | input | 1 | PLL lock indication |
| pa_locked_i | input | 1 | Phase-alignment lock indication |
| align_done_i | input | 1 | Word alignment succeeded |
| pll_rst_o | output | 1 | PLL reset |
| pa_rst_o | output | 1 | Phase-alignment reset |
| fifo_rst_o | output | 1 | Synchronization FIFO reset |
| bslip_rst_o | output | 1 | Bitslip stage reset |
| align_go_o | output | 1 | Word alignment may proceed |
| link_ready_o | output | 1 | Interface ready |

## Verification
The bench measures every pulse and wait as a run length in cycles and compares it with the value computed from the parameters. A design that shortens the PLL hold, the FIFO pulse, the settling gap or the bitslip pulse by one cycle gives a wrong count. The lock filter is tested with a lock glitch one cycle before qualification. A filter that fails to restart its count releases the phase-alignment reset too early. Alignment completion is driven in the wrong state to show it is ignored. PLL lock is dropped while the interface is ready, and the mode input is flipped mid-run. A sequencer that tracks the live mode, or that does not return to the hold state on lock loss, shows a missing FIFO pulse or a stale ready flag. A non-aligned run with a FIFO-pulse counter confirms that the skipped stages never fire.

// File: rtl/rxinit_pkg.sv
package rxinit_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PLL_HOLD,
        ST_PLL_WAIT,
        ST_PA_WAIT,
        ST_FIFO_RST,
        ST_FIFO_GAP,
        ST_BSLIP_RST,
        ST_ALIGN,
        ST_READY
    } seq_state_e;

    typedef struct packed {
        logic pll_rst;
        logic pa_rst;
        logic fifo_rst;
        logic bslip_rst;
        logic align_go;
        logic link_ready;
    } seq_ctrl_t;

    // Whole cycles covering a duration, never less than one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // States in which a dropped PLL lock forces the sequence back to the hold.
    function automatic logic lock_watched(input seq_state_e s);
        return (s == ST_PA_WAIT) || (s == ST_FIFO_RST) || (s == ST_FIFO_GAP) ||
               (s == ST_BSLIP_RST) || (s == ST_ALIGN) || (s == ST_READY);
    endfunction

endpackage

// File: rtl/rxinit_lock_filter.sv
module rxinit_lock_filter #(
    parameter int unsigned STABLE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic lock_i,
    output logic stable_o
);
    localparam int unsigned CW = $clog2(STABLE_CYC + 1);
    localparam logic [CW-1:0] TARGET = CW'(STABLE_CYC);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i || !lock_i) begin
            run_q <= '0;
        end else if (run_q != TARGET) begin
            run_q <= run_q + CW'(1);
        end
    end

    assign stable_o = (run_q == TARGET);

    // R4: a qualified lock implies the lock input was high at the last edge
    assert_stable_needs_lock_R4: assert property (@(posedge clk) disable iff (rst)
        stable_o |-> $past(lock_i));

endmodule

// File: rtl/rxinit_dwell_timer.sv
module rxinit_dwell_timer #(
    parameter int unsigned MAXV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    output logic [$clog2(MAXV+1)-1:0] count_o
);
    localparam int unsigned W = $clog2(MAXV + 1);
    localparam logic [W-1:0] TOP = W'(MAXV);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q <= '0;
        end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/rxinit_out_decode.sv
module rxinit_out_decode
    import rxinit_pkg::*;
(
    input  seq_state_e state_i,
    input  logic       aligned_i,
    output seq_ctrl_t  ctrl_o
);
    always_comb begin
        ctrl_o = '0;
        case (state_i)
            ST_IDLE, ST_PLL_HOLD: begin
                ctrl_o.pll_rst = 1'b1;
                ctrl_o.pa_rst  = 1'b1;
            end
            ST_PLL_WAIT: ctrl_o.pa_rst = 1'b1;
            ST_PA_WAIT:  ctrl_o.pa_rst = !aligned_i;
            ST_FIFO_RST: begin
                ctrl_o.pa_rst   = !aligned_i;
                ctrl_o.fifo_rst = 1'b1;
            end
            ST_FIFO_GAP: ctrl_o.pa_rst = !aligned_i;
            ST_BSLIP_RST: begin
                ctrl_o.pa_rst    = !aligned_i;
                ctrl_o.bslip_rst = 1'b1;
            end
            ST_ALIGN: begin
                ctrl_o.pa_rst   = !aligned_i;
                ctrl_o.align_go = 1'b1;
            end
            ST_READY: begin
                ctrl_o.pa_rst     = !aligned_i;
                ctrl_o.link_ready = 1'b1;
            end
            default: begin
                ctrl_o.pll_rst = 1'b1;
                ctrl_o.pa_rst  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/rx_bringup_seq.sv
module rx_bringup_seq
    import rxinit_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS   = 20,
    parameter int unsigned PLL_RST_MIN_NS  = 10,
    parameter int unsigned LOCK_STABLE_CYC = 8,
    parameter int unsigned FIFO_RST_CYC    = 1,
    parameter int unsigned FIFO_GAP_CYC    = 2,
    parameter int unsigned BSLIP_RST_CYC   = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req_i,
    input  logic mode_aligned_i,
    input  logic pll_locked_i,
    input  logic pa_locked_i,
    input  logic align_done_i,
    output logic pll_rst_o,
    output logic pa_rst_o,
    output logic fifo_rst_o,
    output logic bslip_rst_o,
    output logic align_go_o,
    output logic link_ready_o
);
    localparam int unsigned HOLD_CYC  = ns_to_cycles(PLL_RST_MIN_NS, CLK_PERIOD_NS);
    localparam int unsigned FIFO_EFF  = max_u(FIFO_RST_CYC, 1);
    localparam int unsigned GAP_EFF   = max_u(FIFO_GAP_CYC, 2);
    localparam int unsigned BSLIP_EFF = max_u(BSLIP_RST_CYC, 1);
    localparam int unsigned TMAX      = max_u(max_u(HOLD_CYC, FIFO_EFF),
                                              max_u(GAP_EFF, BSLIP_EFF));
    localparam int unsigned TW        = $clog2(TMAX + 1);

    seq_state_e    state_q, state_d;
    logic          mode_q;
    logic          lock_ok;
    logic          restart, lock_lost, timer_clear, dwell_done;
    logic [TW-1:0] dwell, lim;
    seq_ctrl_t     ctrl;

    rxinit_lock_filter #(.STABLE_CYC(LOCK_STABLE_CYC)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (ctrl.pll_rst),
        .lock_i   (pll_locked_i),
        .stable_o (lock_ok)
    );

    rxinit_dwell_timer #(.MAXV(TMAX)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear_i (timer_clear),
        .count_o (dwell)
    );

    rxinit_out_decode u_dec (
        .state_i   (state_q),
        .aligned_i (mode_q),
        .ctrl_o    (ctrl)
    );

    // Dwell length of each timed state
    always_comb begin
        case (state_q)
            ST_PLL_HOLD:  lim = TW'(HOLD_CYC);
            ST_FIFO_RST:  lim = TW'(FIFO_EFF);
            ST_FIFO_GAP:  lim = TW'(GAP_EFF);
            ST_BSLIP_RST: lim = TW'(BSLIP_EFF);
            default:      lim = TW'(1);
        endcase
    end

    assign dwell_done = (dwell == (lim - TW'(1)));
    assign restart    = start_req_i;
    assign lock_lost  = lock_watched(state_q) && !pll_locked_i;

    always_comb begin
        state_d = state_q;
        if (restart || lock_lost) begin
            state_d = ST_PLL_HOLD;
        end else begin
            case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_PLL_HOLD:  if (dwell_done) state_d = ST_PLL_WAIT;
                ST_PLL_WAIT:  if (lock_ok) state_d = mode_q ? ST_PA_WAIT : ST_BSLIP_RST;
                ST_PA_WAIT:   if (pa_locked_i) state_d = ST_FIFO_RST;
                ST_FIFO_RST:  if (dwell_done) state_d = ST_FIFO_GAP;
                ST_FIFO_GAP:  if (dwell_done) state_d = ST_BSLIP_RST;
                ST_BSLIP_RST: if (dwell_done) state_d = ST_ALIGN;
                ST_ALIGN:     if (align_done_i) state_d = ST_READY;
                ST_READY:     state_d = ST_READY;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    assign timer_clear = (state_d != state_q) || restart || lock_lost;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_req_i) mode_q <= mode_aligned_i;
        end
    end

    assign pll_rst_o    = ctrl.pll_rst;
    assign pa_rst_o     = ctrl.pa_rst;
    assign fifo_rst_o   = ctrl.fifo_rst;
    assign bslip_rst_o  = ctrl.bslip_rst;
    assign align_go_o   = ctrl.align_go;
    assign link_ready_o = ctrl.link_ready;

    // Checker state: length of the current PLL reset run
    logic [TW-1:0] hold_run;
    always_ff @(posedge clk) begin
        if (rst || !pll_rst_o) hold_run <= '0;
        else if (hold_run != TW'(TMAX)) hold_run <= hold_run + TW'(1);
    end

    assert_pll_hold_width_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_rst_o) |-> (hold_run >= TW'(HOLD_CYC)));

    assert_start_resets_R2: assert property (@(posedge clk) disable iff (rst)
        start_req_i |=> (pll_rst_o && pa_rst_o && !link_ready_o && !align_go_o));

    assert_pa_release_after_lock_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(pa_rst_o) |-> ($past(pll_locked_i) && !pll_rst_o));

    assert_fifo_after_pa_R5: assert property (@(posedge clk) disable iff (rst)
        fifo_rst_o |-> (!pa_rst_o && !pll_rst_o));

    assert_gap_before_bslip_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(bslip_rst_o) |-> (!$past(fifo_rst_o, 1) && !$past(fifo_rst_o, 2)));

    assert_bslip_then_go_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(align_go_o) |-> $past(bslip_rst_o));

    assert_ready_needs_done_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(link_ready_o) |-> ($past(align_done_i) && $past(align_go_o)));

    assert_lock_loss_restart_R10: assert property (@(posedge clk) disable iff (rst)
        ((fifo_rst_o || align_go_o || link_ready_o) && !pll_locked_i) |=> pll_rst_o);

    assert_single_stage_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fifo_rst_o, bslip_rst_o, align_go_o, link_ready_o}));

endmodule

// File: tb/tb_rx_bringup_seq.sv
module tb_rx_bringup_seq;
    localparam int unsigned PERIOD = 20;
    localparam int unsigned PLL_NS = 50;
    localparam int unsigned LCYC   = 4;
    localparam int unsigned FCYC   = 2;
    localparam int unsigned GCYC   = 3;
    localparam int unsigned BCYC   = 2;
    localparam int EXP_HOLD = (PLL_NS + PERIOD - 1) / PERIOD;

    localparam int I_PLL = 0, I_PA = 1, I_FIFO = 2, I_BS = 3, I_GO = 4, I_RDY = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0, mode_al = 1'b1, pll_lk = 1'b0, pa_lk = 1'b0, al_done = 1'b0;
    logic pll_rst, pa_rst, fifo_rst, bs_rst, go, rdy;
    logic [5:0] obs;

    int n_cmp = 0, n_bad = 0, fifo_hits = 0, n;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    rx_bringup_seq #(
        .CLK_PERIOD_NS(PERIOD), .PLL_RST_MIN_NS(PLL_NS), .LOCK_STABLE_CYC(LCYC),
        .FIFO_RST_CYC(FCYC), .FIFO_GAP_CYC(GCYC), .BSLIP_RST_CYC(BCYC)
    ) dut (
        .clk(clk), .rst(rst), .start_req_i(start_req), .mode_aligned_i(mode_al),
        .pll_locked_i(pll_lk), .pa_locked_i(pa_lk), .align_done_i(al_done),
        .pll_rst_o(pll_rst), .pa_rst_o(pa_rst), .fifo_rst_o(fifo_rst),
        .bslip_rst_o(bs_rst), .align_go_o(go), .link_ready_o(rdy)
    );

    assign obs = {rdy, go, bs_rst, fifo_rst, pa_rst, pll_rst};

    always @(negedge clk) if (!rst && fifo_rst) fifo_hits++;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Count consecutive samples (starting with the current one) at the given level.
    task automatic run_len(input int idx, input logic lvl, output int cnt);
        cnt = 0;
        while (obs[idx] == lvl && cnt < 200) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_start(input logic m);
        mode_al = m;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 idle state
        chk("R1 pll_rst", pll_rst, 1); chk("R1 pa_rst", pa_rst, 1);
        chk("R1 others", int'(obs[5:2]), 0);
        repeat (3) @(negedge clk);
        chk("R1 idle hold", int'(obs), 3);

        // ---- phase-aligned run ----
        pulse_start(1'b1);
        chk("R2 start pll", pll_rst, 1); chk("R2 start pa", pa_rst, 1);
        run_len(I_PLL, 1'b1, n);
        chk("R3 pll hold cycles", n, EXP_HOLD);
        chk("R4 pa held before lock", pa_rst, 1);
        pll_lk = 1'b1;
        repeat (LCYC - 1) @(negedge clk);
        chk("R4 not yet qualified", pa_rst, 1);
        pll_lk = 1'b0;
        @(negedge clk);
        pll_lk = 1'b1;
        run_len(I_PA, 1'b1, n);
        chk("R4 lock qualify after glitch", n, LCYC + 1);
        al_done = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 waits for pa lock", fifo_rst, 0);
        chk("R8 done ignored ready", rdy, 0);
        chk("R8 done ignored go", go, 0);
        al_done = 1'b0;
        pa_lk = 1'b1;
        @(negedge clk);
        run_len(I_FIFO, 1'b1, n);
        chk("R5 fifo pulse", n, FCYC);
        run_len(I_BS, 1'b0, n);
        chk("R6 gap", n, GCYC);
        chk("R6 fifo low at bslip", fifo_rst, 0);
        run_len(I_BS, 1'b1, n);
        chk("R6 bslip pulse", n, BCYC);
        chk("R8 go raised", go, 1);
        mode_al = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 go held", go, 1);
        chk("R11 mode change ignored", pa_rst, 0);
        al_done = 1'b1;
        @(negedge clk);
        al_done = 1'b0;
        chk("R9 ready", rdy, 1); chk("R9 go dropped", go, 0);
        repeat (3) @(negedge clk);
        chk("R9 ready held", rdy, 1);

        // R10 lock loss while ready
        pll_lk = 1'b0;
        @(negedge clk);
        chk("R10 pll reasserted", pll_rst, 1); chk("R10 pa reasserted", pa_rst, 1);
        chk("R10 ready cleared", rdy, 0);
        run_len(I_PLL, 1'b1, n);
        chk("R10 hold again", n, EXP_HOLD);
        pll_lk = 1'b1;
        run_len(I_PA, 1'b1, n);
        chk("R4 qualify again", n, LCYC + 1);
        run_len(I_FIFO, 1'b0, n);
        chk("R11 latched aligned mode reaches fifo", n, 1);
        run_len(I_FIFO, 1'b1, n);
        chk("R11 fifo pulse", n, FCYC);

        // ---- non-aligned run (restart mid-sequence) ----
        pulse_start(1'b0);
        chk("R2 restart pll", pll_rst, 1); chk("R2 restart others", int'(obs[5:2]), 0);
        fifo_hits = 0;
        run_len(I_PLL, 1'b1, n);
        chk("R3 hold nonaligned", n, EXP_HOLD);
        run_len(I_BS, 1'b0, n);
        chk("R7 bslip after qualify", n, LCYC + 1);
        chk("R7 pa stays reset", pa_rst, 1);
        run_len(I_BS, 1'b1, n);
        chk("R7 bslip pulse", n, BCYC);
        chk("R8 go nonaligned", go, 1);
        chk("R7 no fifo pulse", fifo_hits, 0);
        al_done = 1'b1;
        @(negedge clk);
        al_done = 1'b0;
        chk("R9 ready nonaligned", rdy, 1);
        pulse_start(1'b0);
        chk("R9 ready cleared on restart", rdy, 0);
        chk("R2 pll after restart", pll_rst, 1);

        finish_run();
    end
endmodule